// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit device virtual address into a physical address. It walks a two-level translation structure held in memory. One request comes in on a valid/ready handshake and carries the virtual address and an access direction, read or write. The walker then issues up to two single-word reads on a request/response memory port. The first read fetches a directory entry and the second fetches a page entry. It returns exactly one result: a translated address, a page fault or a bus error.

The virtual address splits into three fields. Bits 31:22 are the directory index, bits 21:12 are the page-table index and bits 11:0 are the page offset. Each table has 1024 four-byte entries, so one table fills exactly one 4 KiB frame. Both kinds of entry carry a frame number in bits 31:12 and a present flag in bit 0. A page entry also carries permission flags. Translation caching and software-visible registers sit outside this block.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.
- R2: Only one walk is in flight at a time. `req_ready` is 1 only when no walk and no pending result exist. The result is presented no earlier than the cycle after acceptance.
- R3: The first memory read targets `dir_base` with bits 11:0 cleared, plus 4 times virtual address bits 31:22.
- R4: When the directory entry has bit 0 set, the second read targets that entry's bits 31:12 followed by twelve zero bits, plus 4 times virtual address bits 21:12.
- R5: A directory entry with bit 0 clear ends the walk with status 2'b01 (page fault). No second read is issued.
- R6: A page entry with bit 0 clear ends the walk with status 2'b01.
- R7: A write needs page-entry bit 2 set and a read needs page-entry bit 1 set. Otherwise the status is 2'b01. Page-entry bits 11:3 and directory-entry bits 11:1 have no effect.
- R8: A successful walk returns status 2'b00. `rsp_paddr` is then page-entry bits 31:12 concatenated with virtual address bits 11:0. On any other status `rsp_paddr` is 0.
- R9: On status 2'b01 or 2'b10, `rsp_fault_addr` equals the virtual address of the request and `rsp_fault_write` equals its `req_write`.
- R10: A response with `mem_rsp_err` set, on either read, ends the walk with status 2'b10 (bus error). This happens whatever the response data holds.
- R11: Once raised, `mem_req_valid` stays high and `mem_req_addr` stays constant until the cycle in which `mem_req_ready` is high.
- R12: Once raised, `rsp_valid` and every result field stay constant until the cycle in which `rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| dir_base | input | 32 | Directory table base (bits 11:0 ignored) |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word read |
| mem_rsp_err | input | 1 | Read ended in error |
| rsp_valid | output | 1 | Walk result present |
| rsp_ready | input | 1 | Result consumed |
| rsp_status | output | 2 | 00 ok, 01 page fault, 10 bus error |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_fault_addr | output | 32 | Virtual address of a failed walk |
| rsp_fault_write | output | 1 | Direction of a failed walk |

## Verification
The bench sweeps directory and page indices, including the top index 1023, across both access directions and with memory back-pressure on and off. Its memory model derives every entry from the indices, so present bits, permissions and injected read errors cover every path of the walk. A walker that fetched a page entry after an absent directory entry would show up through an extra read or a wrong read address. Swapped permission bits would fault the wrong direction, and a walker that let entry data override an error flag would report a page fault instead of a bus error. Results held back for several cycles must not change, and a walker that dropped the offset or kept stale addresses on faults would miscompare on `rsp_paddr`.

// File: rtl/ptw_pkg.sv
// Package: shared constants and types for the page table walker.
// Assumes 4-byte table entries; bit positions below are decoded by the walker.
package ptw_pkg;
    localparam int ENTRY_BYTES_LOG2 = 2;
    localparam int BIT_PRESENT      = 0;
    localparam int BIT_READ_OK      = 1;
    localparam int BIT_WRITE_OK     = 2;

    typedef enum logic [2:0] {
        W_IDLE,
        W_DIR_REQ,
        W_DIR_WAIT,
        W_PTE_REQ,
        W_PTE_WAIT,
        W_RESULT
    } walk_state_t;

    typedef enum logic [1:0] {
        ST_OK    = 2'b00,
        ST_FAULT = 2'b01,
        ST_BUS   = 2'b10
    } walk_status_t;
endpackage

// File: rtl/ptw_entry_addr.sv
// Module: byte address of one table entry.
// Assumes the table base is aligned to ALIGN_W bits, so the low bits of the
// base are dropped, and adds the scaled index.
module ptw_entry_addr #(
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 10,
    parameter int ALIGN_W = 12
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] entry_addr
);
    import ptw_pkg::*;

    localparam int PAD_W = ADDR_W - IDX_W - ENTRY_BYTES_LOG2;

    logic [ADDR_W-1:0] aligned_base;
    logic [ADDR_W-1:0] scaled_index;

    // Align the base and add the index scaled by the entry size.
    always_comb begin
        aligned_base = {base[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
        scaled_index = {{PAD_W{1'b0}}, index, {ENTRY_BYTES_LOG2{1'b0}}};
        entry_addr   = aligned_base + scaled_index;
    end
endmodule

// File: rtl/ptw_entry_decode.sv
// Module: decode of a fetched table entry.
// Assumes frame number in the upper bits, present flag in bit 0, and for leaf
// (page) entries read/write permission in bits 1 and 2.
module ptw_entry_decode #(
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 12
) (
    input  logic [ADDR_W-1:0] entry,
    input  logic              is_leaf,
    input  logic              is_write,
    output logic              present,
    output logic              allowed,
    output logic [ADDR_W-1:0] frame_addr
);
    import ptw_pkg::*;

    // Extract presence, permission verdict and frame address.
    always_comb begin
        present    = entry[BIT_PRESENT];
        frame_addr = {entry[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
        if (is_leaf)
            allowed = is_write ? entry[BIT_WRITE_OK] : entry[BIT_READ_OK];
        else
            allowed = 1'b1;
    end
endmodule

// File: rtl/ptw_walker.sv
// Module: two-level page table walker (top).
// Accepts one translation at a time, reads the directory entry and then the
// page entry through a single-outstanding memory read port, and holds one
// result until it is consumed. Assumes the memory returns exactly one
// response per accepted read, and only while the walker waits for it.
module ptw_walker #(
    parameter int ADDR_W    = 32,
    parameter int DIR_IDX_W = 10,
    parameter int PT_IDX_W  = 10,
    parameter int PAGE_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] dir_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_status,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [ADDR_W-1:0] rsp_fault_addr,
    output logic              rsp_fault_write
);
    import ptw_pkg::*;

    localparam int DIR_LSB = PT_IDX_W + PAGE_W;
    localparam int DIR_MSB = DIR_LSB + DIR_IDX_W - 1;
    localparam int PT_MSB  = PAGE_W + PT_IDX_W - 1;

    walk_state_t       state;
    logic [ADDR_W-1:0] va_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    walk_status_t      status_q;
    logic [ADDR_W-1:0] paddr_q;

    logic [ADDR_W-1:0] dir_entry_addr;
    logic [ADDR_W-1:0] pte_entry_addr;
    logic              ent_present;
    logic              ent_allowed;
    logic [ADDR_W-1:0] ent_frame;
    logic              in_leaf;
    logic              rsp_arrives;

    // Directory entry address from the incoming request.
    ptw_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(DIR_IDX_W), .ALIGN_W(PAGE_W)) u_dir_addr (
        .base       (dir_base),
        .index      (req_vaddr[DIR_MSB:DIR_LSB]),
        .entry_addr (dir_entry_addr)
    );

    // Decode of whichever entry is being returned.
    ptw_entry_decode #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_decode (
        .entry      (mem_rsp_data),
        .is_leaf    (in_leaf),
        .is_write   (wr_q),
        .present    (ent_present),
        .allowed    (ent_allowed),
        .frame_addr (ent_frame)
    );

    // Page entry address from the returned directory entry.
    ptw_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(PT_IDX_W), .ALIGN_W(PAGE_W)) u_pte_addr (
        .base       (ent_frame),
        .index      (va_q[PT_MSB:PAGE_W]),
        .entry_addr (pte_entry_addr)
    );

    // Status flags that the handshake outputs are built from.
    always_comb begin
        in_leaf     = (state == W_PTE_WAIT);
        rsp_arrives = mem_rsp_valid &&
                      ((state == W_DIR_WAIT) || (state == W_PTE_WAIT));
    end

    // Walk sequencer: request capture, two fetches, result hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= W_IDLE;
            va_q     <= '0;
            wr_q     <= 1'b0;
            addr_q   <= '0;
            status_q <= ST_OK;
            paddr_q  <= '0;
        end else begin
            case (state)
                W_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_vaddr;
                        wr_q   <= req_write;
                        addr_q <= dir_entry_addr;
                        state  <= W_DIR_REQ;
                    end
                end
                W_DIR_REQ: begin
                    if (mem_req_ready) state <= W_DIR_WAIT;
                end
                W_DIR_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            status_q <= ST_BUS;
                            paddr_q  <= '0;
                            state    <= W_RESULT;
                        end else if (!ent_present) begin
                            status_q <= ST_FAULT;
                            paddr_q  <= '0;
                            state    <= W_RESULT;
                        end else begin
                            addr_q <= pte_entry_addr;
                            state  <= W_PTE_REQ;
                        end
                    end
                end
                W_PTE_REQ: begin
                    if (mem_req_ready) state <= W_PTE_WAIT;
                end
                W_PTE_WAIT: begin
                    if (mem_rsp_valid) begin
                        state <= W_RESULT;
                        if (mem_rsp_err) begin
                            status_q <= ST_BUS;
                            paddr_q  <= '0;
                        end else if (!ent_present || !ent_allowed) begin
                            status_q <= ST_FAULT;
                            paddr_q  <= '0;
                        end else begin
                            status_q <= ST_OK;
                            paddr_q  <= ent_frame | {{(ADDR_W-PAGE_W){1'b0}}, va_q[PAGE_W-1:0]};
                        end
                    end
                end
                W_RESULT: begin
                    if (rsp_ready) state <= W_IDLE;
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    // Port view of the sequencer state.
    always_comb begin
        req_ready       = (state == W_IDLE);
        mem_req_valid   = (state == W_DIR_REQ) || (state == W_PTE_REQ);
        mem_req_addr    = addr_q;
        rsp_valid       = (state == W_RESULT);
        rsp_status      = status_q;
        rsp_paddr       = paddr_q;
        rsp_fault_addr  = va_q;
        rsp_fault_write = wr_q;
    end

    // R2: an accepted request blocks the next one for at least a cycle.
    a_r2_single_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R5: an absent directory entry issues no page-entry read.
    a_r5_no_second_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state == W_DIR_WAIT && mem_rsp_valid && !mem_rsp_err && !mem_rsp_data[0])
        |=> (!mem_req_valid && rsp_valid && rsp_status == ST_FAULT));

    // R10: an error response always ends the walk as a bus error.
    a_r10_bus_error: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_arrives && mem_rsp_err) |=> (rsp_valid && rsp_status == ST_BUS));

    // R11: a memory read request is held until taken.
    a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R12: a result is held until consumed.
    a_r12_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) &&
                                       $stable(rsp_paddr) && $stable(rsp_fault_addr) &&
                                       $stable(rsp_fault_write)));
endmodule

// File: tb/ptw_walker_tb.sv
// Bench: sweeps directory/page indices and both directions against a
// memory model whose entries are computed from the indices.
module ptw_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [31:0] dir_base = 32'h0001_0ABC;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_paddr;
    logic [31:0] rsp_fault_addr;
    logic        rsp_fault_write;

    int          n_chk = 0;
    int          n_bad = 0;
    int          rd_cnt = 0;
    int          cyc = 0;
    logic        stall_on = 1'b0;
    logic [31:0] exp_a0 = '0;
    logic [31:0] exp_a1 = '0;

    always #10 clk = ~clk;

    ptw_walker u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .dir_base(dir_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
        .rsp_paddr(rsp_paddr), .rsp_fault_addr(rsp_fault_addr),
        .rsp_fault_write(rsp_fault_write)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] frame_of(input int d, input int p);
        return 20'((d * 1024 + p) ^ 32'h5A5A5);
    endfunction

    // Directory entry: frame 0x100+d, junk in 11:1, present unless d%4==0.
    function automatic logic [31:0] dte_of(input int d);
        return {20'(32'h100 + d), 11'h2A5, 1'(d % 4 != 0)};
    endfunction

    // Page entry: junk in 11:3, write bit2, read bit1, present bit0.
    function automatic logic [31:0] pte_of(input int d, input int p);
        logic [5:0] pj;
        pj = 6'(p);
        return {frame_of(d, p), 3'b101, pj, 1'(p % 3 != 2), 1'(p % 3 != 1), 1'(p % 5 != 0)};
    endfunction

    // Memory model: one response one cycle after each accepted read.
    initial begin
        logic        pending;
        logic [31:0] a;
        int          d;
        int          p;
        pending = 1'b0;
        a = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            if (pending) begin
                if (a[31:12] == 20'h00010) begin
                    d = int'(a[11:2]);
                    mem_rsp_data = dte_of(d);
                    mem_rsp_err  = (d == 7);
                end else begin
                    d = int'(a[31:12]) - 32'h100;
                    p = int'(a[11:2]);
                    mem_rsp_data = pte_of(d, p);
                    mem_rsp_err  = (p == 13);
                end
                mem_rsp_valid = 1'b1;
                pending = 1'b0;
            end
            mem_req_ready = !stall_on || (cyc % 3 == 0);
            if (mem_req_valid && mem_req_ready) begin
                a = mem_req_addr;
                pending = 1'b1;
                if (rd_cnt == 0) chk(a == exp_a0, "R3 directory read address", a, exp_a0);
                else             chk(a == exp_a1, "R4 page read address", a, exp_a1);
                rd_cnt++;
            end
        end
    end

    task automatic walk(input int d, input int p, input int off, input bit wr, input int hold);
        logic [31:0] va;
        logic [1:0]  est;
        logic [31:0] epa;
        int          nrd;
        string       tag;
        logic [1:0]  st0;
        logic [31:0] pa0;
        va  = {10'(d), 10'(p), 12'(off)};
        exp_a0 = 32'h0001_0000 + 32'(d * 4);
        exp_a1 = ((32'h100 + 32'(d)) << 12) + 32'(p * 4);
        epa = '0;
        nrd = 2;
        if (d == 7)                               begin est = 2'b10; nrd = 1; tag = "R10 directory error"; end
        else if (d % 4 == 0)                      begin est = 2'b01; nrd = 1; tag = "R5 absent directory"; end
        else if (p == 13)                         begin est = 2'b10; tag = "R10 page error"; end
        else if (p % 5 == 0)                      begin est = 2'b01; tag = "R6 absent page"; end
        else if (wr ? (p % 3 == 2) : (p % 3 == 1)) begin est = 2'b01; tag = "R7 permission"; end
        else begin est = 2'b00; epa = {frame_of(d, p), 12'(off)}; tag = "R8 translation"; end
        rd_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_vaddr = 32'hDEAD_BEEF; req_write = ~wr;
        while (!rsp_valid) @(negedge clk);
        chk(req_ready == 1'b0, "R2 busy while result pending", 32'(req_ready), 32'h0);
        st0 = rsp_status; pa0 = rsp_paddr;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_status == st0 && rsp_paddr == pa0,
                "R12 result held", {rsp_paddr[29:0], rsp_status}, {pa0[29:0], st0});
        end
        chk(rsp_status == est, tag, 32'(rsp_status), 32'(est));
        chk(rsp_paddr == epa, "R8 physical address", rsp_paddr, epa);
        chk(rd_cnt == nrd, "R5 read count", 32'(rd_cnt), 32'(nrd));
        if (est != 2'b00) begin
            chk(rsp_fault_addr == va, "R9 fault address", rsp_fault_addr, va);
            chk(rsp_fault_write == wr, "R9 fault direction", 32'(rsp_fault_write), 32'(wr));
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'h1);
        chk(mem_req_valid == 1'b0, "R1 no read after reset", 32'(mem_req_valid), 32'h0);
        chk(rsp_valid == 1'b0, "R1 no result after reset", 32'(rsp_valid), 32'h0);
        for (int s = 0; s < 2; s++) begin
            stall_on = 1'(s);
            for (int i = 0; i < 13; i++) begin
                for (int j = 0; j < 17; j++) begin
                    for (int w = 0; w < 2; w++) begin
                        int d;
                        int p;
                        int off;
                        d = (i == 12) ? 1023 : i;
                        p = (j == 16) ? 1023 : j;
                        off = (j == 15) ? 12'hFFF : ((d * 37 + p * 11 + w * 2048) & 12'hFFF);
                        walk(d, p, off, 1'(w), (p % 4 == 3) ? 2 : 0);
                    end
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule